// File: doc/BRIEF.md
# Auto-Refresh Scheduler with Deferred-Refresh Debt

This block decides when a DDR2-style memory controller should send auto-refresh commands. An interval timer expires once every programmed refresh interval and adds one owed refresh to a debt counter. The debt counter goes down by one each time the block sees a refresh command on the controller's issued command stream. While the debt is between one and seven, the controller may put the refresh off and keep serving traffic. When the debt reaches eight, the urgent flag asks it to drain the refresh backlog before doing anything else. With at most eight refreshes owed, the gap between two refreshes never exceeds nine intervals.

A refresh may only be sent when every bank has been precharged and idle for the programmed precharge time. The block tracks this from a bank-idle status input and from the precharge commands it sees. When the request is pending and the banks qualify, the block drives the refresh encoding on its own chip-select, row-strobe, column-strobe and write-enable outputs. At all other times those outputs are deselected. The controller stays responsible for sending the precharge-all that empties the banks. After each refresh the block raises a busy window for the programmed refresh cycle time. Activates and further refreshes must wait for that window to close. A refresh sent while the banks do not qualify, or while the window is still open, raises a one-cycle violation pulse.

A four-state machine sets the outputs:
- `ST_QUIET`: no debt.
- `ST_OWED`: debt 1 to 7, so the request is active.
- `ST_URGENT`: debt of 8 or more, so the request and the urgent flag are both active.
- `ST_RFC`: the post-refresh lockout, with requests masked and busy high.

The transitions are:
- Any state goes to `ST_RFC` when a refresh is seen and the cycle time is nonzero.
- `ST_RFC` holds until the lockout counter reaches its last cycle.
- Otherwise the next state follows the next debt value: zero gives `ST_QUIET`, 1 to 7 gives `ST_OWED`, and 8 or more gives `ST_URGENT`.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the debt reads 0. At that time ref_req, ref_urgent, rfc_busy and violation are all 0, and the refresh command outputs are deselected (all four at 1).
- R2: The interval timer expires once every cfg_trefi clock cycles, counted from reset release. Each expiry raises the debt by one in the following cycle, so the first increment appears after cfg_trefi rising edges.
- R3: A refresh is decoded on the command inputs as chip-select, row-strobe and column-strobe low with write-enable high, sampled on a rising edge. Each such command lowers the debt by one, but never below 0. An expiry and a refresh in the same cycle leave the debt unchanged. The debt saturates at 9.
- R4: ref_req is 1 exactly when the debt is nonzero and the lockout window is not open.
- R5: ref_urgent is 1 exactly when the debt is 8 or more and the lockout window is not open.
- R6: The refresh command outputs {cs_n,ras_n,cas_n,we_n} carry 4'b0001 in a cycle where ref_req is 1 and the banks qualify as idle. In every other cycle they carry 4'b1111.
- R7: The banks qualify as idle when bank_idle is 1 now and has been 1 for at least cfg_trp rising edges. No precharge command ({cs_n,ras_n,cas_n,we_n} = 4'b0010) may have been sampled on those edges. Either a low bank_idle or a precharge restarts the count.
- R8: After a refresh is sampled, rfc_busy stays 1 for cfg_trfc cycles, and a refresh sampled inside that window restarts it.
- R9: violation is 1 for one cycle after a refresh is sampled while the banks do not qualify as idle or while rfc_busy is 1. It is 0 after a refresh that met both conditions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_trefi | input | TREFI_W | Refresh interval in clocks (at least 2) |
| cfg_trfc | input | TRFC_W | Refresh cycle lockout in clocks |
| cfg_trp | input | TRP_W | Required idle time before refresh, in clocks |
| bank_idle | input | 1 | All banks precharged |
| cmd_cs_n | input | 1 | Issued command: chip select, active low |
| cmd_ras_n | input | 1 | Issued command: row strobe, active low |
| cmd_cas_n | input | 1 | Issued command: column strobe, active low |
| cmd_we_n | input | 1 | Issued command: write enable, active low |
| ref_req | output | 1 | Refresh owed and allowed to be scheduled |
| ref_urgent | output | 1 | Debt limit reached; refresh must go first |
| ref_cs_n | output | 1 | Proposed refresh command: chip select |
| ref_ras_n | output | 1 | Proposed refresh command: row strobe |
| ref_cas_n | output | 1 | Proposed refresh command: column strobe |
| ref_we_n | output | 1 | Proposed refresh command: write enable |
| rfc_busy | output | 1 | Lockout window; activate and refresh blocked |
| violation | output | 1 | One-cycle pulse after an illegal refresh |
| ref_debt | output | DEBT_W | Number of owed refreshes |

## Verification
The assertions assume the timing inputs change only while reset is held, with one exception: cfg_trefi may rise at run time, because the interval counter is then still below the new limit. They also assume cfg_trefi is at least 2. The command inputs carry at most one command per cycle. The bench meets these assumptions. It draws a fresh set of timing values only inside a reset, and it raises cfg_trefi once during the directed part. Its random traffic still sends refreshes that break the idle or lockout rules, along with precharges and activates, so that the violation and idle-restart paths are exercised.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_OWED   = 2'd1,
        ST_URGENT = 2'd2,
        ST_RFC    = 2'd3
    } sched_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ddr_cmd_t;

    localparam ddr_cmd_t CMD_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam ddr_cmd_t CMD_PRE   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam ddr_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = (cnt == period - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R2: one expiry, then at least one quiet cycle when the period exceeds one
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && period > 1) |=> !tick);

endmodule

// File: rtl/rfs_idle_qual.sv
module rfs_idle_qual #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] need,
    input  logic         bank_idle,
    input  logic         pre_seen,
    output logic         idle_ok
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (!bank_idle || pre_seen) cnt <= '0;
        else if (cnt != '1)             cnt <= cnt + 1'b1;
    end

    assign idle_ok = bank_idle && (cnt >= need);

    // R7: a freshly idle bank set cannot qualify when a precharge time is required
    p_fresh_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bank_idle) && need != '0) |-> !idle_ok);

endmodule

// File: rtl/rfs_rfc_lock.sv
module rfs_rfc_lock #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         busy,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= len;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign last = (cnt == W'(1));

    // R8: a nonzero lockout opens the window on the next cycle
    p_lock_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && len != '0) |=> busy);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import rfs_pkg::*;
#(
    parameter int TREFI_W   = 16,
    parameter int TRFC_W    = 10,
    parameter int TRP_W     = 8,
    parameter int DEBT_MAX  = 9,
    parameter int URGENT_AT = 8,
    localparam int DEBT_W   = $clog2(DEBT_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TREFI_W-1:0] cfg_trefi,
    input  logic [TRFC_W-1:0]  cfg_trfc,
    input  logic [TRP_W-1:0]   cfg_trp,
    input  logic               bank_idle,
    input  logic               cmd_cs_n,
    input  logic               cmd_ras_n,
    input  logic               cmd_cas_n,
    input  logic               cmd_we_n,
    output logic               ref_req,
    output logic               ref_urgent,
    output logic               ref_cs_n,
    output logic               ref_ras_n,
    output logic               ref_cas_n,
    output logic               ref_we_n,
    output logic               rfc_busy,
    output logic               violation,
    output logic [DEBT_W-1:0]  ref_debt
);
    localparam logic [DEBT_W-1:0] DEBT_TOP = DEBT_W'(DEBT_MAX);
    localparam logic [DEBT_W-1:0] DEBT_URG = DEBT_W'(URGENT_AT);

    ddr_cmd_t     seen_cmd, out_cmd;
    logic         ref_seen, pre_seen;
    logic         tick, idle_ok, lock_busy, lock_last;
    logic [DEBT_W-1:0] debt, debt_nxt;
    sched_state_t state, state_nxt;

    assign seen_cmd = '{cs_n: cmd_cs_n, ras_n: cmd_ras_n, cas_n: cmd_cas_n, we_n: cmd_we_n};
    assign ref_seen = (seen_cmd == CMD_REF);
    assign pre_seen = (seen_cmd == CMD_PRE);

    rfs_interval_timer #(.W(TREFI_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .period(cfg_trefi), .tick(tick)
    );

    rfs_idle_qual #(.W(TRP_W)) u_idle (
        .clk(clk), .rst_n(rst_n), .need(cfg_trp), .bank_idle(bank_idle),
        .pre_seen(pre_seen), .idle_ok(idle_ok)
    );

    rfs_rfc_lock #(.W(TRFC_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .load(ref_seen), .len(cfg_trfc),
        .busy(lock_busy), .last(lock_last)
    );

    // Owed-refresh bookkeeping
    always_comb begin
        if (tick && !ref_seen)
            debt_nxt = (debt == DEBT_TOP) ? debt : debt + 1'b1;
        else if (ref_seen && !tick && debt != '0)
            debt_nxt = debt - 1'b1;
        else
            debt_nxt = debt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) debt <= '0;
        else        debt <= debt_nxt;
    end

    // Next-state selection
    always_comb begin
        if (ref_seen && cfg_trfc != '0)
            state_nxt = ST_RFC;
        else if (state == ST_RFC && !lock_last && !ref_seen)
            state_nxt = ST_RFC;
        else if (debt_nxt >= DEBT_URG)
            state_nxt = ST_URGENT;
        else if (debt_nxt != '0)
            state_nxt = ST_OWED;
        else
            state_nxt = ST_QUIET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= state_nxt;
    end

    // Outputs decoded from the state
    always_comb begin
        ref_req    = 1'b0;
        ref_urgent = 1'b0;
        rfc_busy   = 1'b0;
        unique case (state)
            ST_QUIET:  ;
            ST_OWED:   ref_req = 1'b1;
            ST_URGENT: begin
                ref_req    = 1'b1;
                ref_urgent = 1'b1;
            end
            ST_RFC:    rfc_busy = 1'b1;
            default:   ;
        endcase
    end

    assign out_cmd   = (ref_req && idle_ok) ? CMD_REF : CMD_DESEL;
    assign ref_cs_n  = out_cmd.cs_n;
    assign ref_ras_n = out_cmd.ras_n;
    assign ref_cas_n = out_cmd.cas_n;
    assign ref_we_n  = out_cmd.we_n;
    assign ref_debt  = debt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) violation <= 1'b0;
        else        violation <= ref_seen && (!idle_ok || lock_busy);
    end

    // R3: debt never passes its ceiling
    p_debt_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= DEBT_TOP);

    // R2: an expiry without a refresh raises the debt by one
    p_tick_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ref_seen && debt < DEBT_TOP) |=> (debt == $past(debt) + 1'b1));

    // R5: urgency implies the debt limit
    p_urgent_debt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (debt >= DEBT_URG));

    // R8: lockout state agrees with the lockout counter
    p_busy_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rfc_busy == lock_busy);

    // R6: a proposed refresh only when banks qualify and no lockout
    p_ref_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_cs_n |-> (idle_ok && !lock_busy && debt != '0));

    // R9: refresh during lockout is flagged
    p_viol_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_seen && lock_busy) |=> violation);

endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
    localparam int TW = 16;
    localparam int FW = 10;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [TW-1:0] cfg_trefi;
    logic [FW-1:0] cfg_trfc;
    logic [PW-1:0] cfg_trp;
    logic bank_idle;
    logic c_cs, c_ras, c_cas, c_we;
    logic ref_req, ref_urgent, r_cs, r_ras, r_cas, r_we, rfc_busy, violation;
    logic [3:0] ref_debt;

    refresh_sched uut (
        .clk(clk), .rst_n(rst_n), .cfg_trefi(cfg_trefi), .cfg_trfc(cfg_trfc),
        .cfg_trp(cfg_trp), .bank_idle(bank_idle),
        .cmd_cs_n(c_cs), .cmd_ras_n(c_ras), .cmd_cas_n(c_cas), .cmd_we_n(c_we),
        .ref_req(ref_req), .ref_urgent(ref_urgent),
        .ref_cs_n(r_cs), .ref_ras_n(r_ras), .ref_cas_n(r_cas), .ref_we_n(r_we),
        .rfc_busy(rfc_busy), .violation(violation), .ref_debt(ref_debt)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    int m_cnt, m_debt, m_idle, m_rfc;
    bit m_viol;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_debt = 0; m_idle = 0; m_rfc = 0; m_viol = 0;
        end else begin : model_step
            bit rs, ps, tk, ok;
            rs = ({c_cs, c_ras, c_cas, c_we} == 4'b0001);
            ps = ({c_cs, c_ras, c_cas, c_we} == 4'b0010);
            tk = (m_cnt == int'(cfg_trefi) - 1);
            ok = bank_idle && (m_idle >= int'(cfg_trp));
            m_viol = rs && (!ok || m_rfc != 0);
            if (tk && !rs)                    m_debt = (m_debt < 9) ? m_debt + 1 : 9;
            else if (rs && !tk && m_debt > 0) m_debt = m_debt - 1;
            m_cnt  = tk ? 0 : m_cnt + 1;
            m_idle = (!bank_idle || ps) ? 0 : ((m_idle < 255) ? m_idle + 1 : 255);
            m_rfc  = rs ? int'(cfg_trfc) : ((m_rfc > 0) ? m_rfc - 1 : 0);
        end
    end

    function automatic bit exp_busy();
        return m_rfc != 0;
    endfunction
    function automatic bit exp_req();
        return !exp_busy() && m_debt != 0;
    endfunction
    function automatic bit exp_urgent();
        return !exp_busy() && m_debt >= 8;
    endfunction
    function automatic logic [3:0] exp_cmd();
        return (exp_req() && bank_idle && m_idle >= int'(cfg_trp)) ? 4'b0001 : 4'b1111;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R3 debt", ref_debt, m_debt);
        chk("R4 ref_req", ref_req, exp_req());
        chk("R5 ref_urgent", ref_urgent, exp_urgent());
        chk("R8 rfc_busy", rfc_busy, exp_busy());
        chk("R6 refresh command", {r_cs, r_ras, r_cas, r_we}, exp_cmd());
        chk("R9 violation", violation, m_viol);
    endtask

    task automatic cyc();
        @(negedge clk);
        check_all();
    endtask

    task automatic drive(input logic [3:0] c);
        {c_cs, c_ras, c_cas, c_we} = c;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        cfg_trefi = 16'd5; cfg_trfc = 10'd4; cfg_trp = 8'd3;
        bank_idle = 1'b0;
        drive(4'b1111);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 debt at reset", ref_debt, 0);
        chk("R1 req at reset", ref_req, 0);
        chk("R1 busy at reset", rfc_busy, 0);
        chk("R1 violation at reset", violation, 0);
        chk("R1 command at reset", {r_cs, r_ras, r_cas, r_we}, 4'b1111);
        rst_n = 1'b1;
        cyc();
        chk("R1 debt first cycle", ref_debt, 0);

        // R2: first expiry after five edges
        repeat (3) cyc();
        chk("R2 no debt before interval", ref_debt, 0);
        cyc();
        chk("R2 debt after one interval", ref_debt, 1);
        chk("R4 request with debt", ref_req, 1);
        chk("R6 deselect while banks busy", {r_cs, r_ras, r_cas, r_we}, 4'b1111);
        repeat (35) cyc();
        chk("R5 urgent at eight", ref_urgent, 1);
        chk("R3 debt eight", ref_debt, 8);
        repeat (15) cyc();
        chk("R3 saturation at nine", ref_debt, 9);

        // Slow the timer so the directed sequence sees no expiry
        cfg_trefi = 16'd1000;
        bank_idle = 1'b1;
        cyc();
        chk("R7 not yet idle long enough", {r_cs, r_ras, r_cas, r_we}, 4'b1111);
        cyc();
        cyc();
        chk("R6 refresh encoding offered", {r_cs, r_ras, r_cas, r_we}, 4'b0001);

        drive(4'b0001);
        cyc();
        drive(4'b1111);
        chk("R3 debt after legal refresh", ref_debt, 8);
        chk("R8 busy after refresh", rfc_busy, 1);
        chk("R8 request masked in lockout", ref_req, 0);
        chk("R9 legal refresh no violation", violation, 0);

        drive(4'b0001);
        cyc();
        drive(4'b1111);
        chk("R9 refresh in lockout flagged", violation, 1);
        chk("R3 debt after second refresh", ref_debt, 7);
        cyc();
        chk("R9 violation lasts one cycle", violation, 0);
        repeat (6) cyc();
        chk("R8 lockout closed", rfc_busy, 0);

        drive(4'b0010);
        cyc();
        drive(4'b1111);
        chk("R7 precharge restarts idle time", {r_cs, r_ras, r_cas, r_we}, 4'b1111);
        repeat (3) cyc();
        chk("R7 qualified again", {r_cs, r_ras, r_cas, r_we}, 4'b0001);

        bank_idle = 1'b0;
        drive(4'b0001);
        cyc();
        drive(4'b1111);
        chk("R9 refresh with banks open flagged", violation, 1);

        // Random phases
        for (int ph = 0; ph < 4; ph++) begin
            rst_n = 1'b0;
            cfg_trefi = TW'(3 + $urandom % 30);
            cfg_trfc  = FW'(1 + $urandom % 12);
            cfg_trp   = PW'($urandom % 6);
            bank_idle = 1'b0;
            drive(4'b1111);
            cyc();
            rst_n = 1'b1;
            for (int i = 0; i < 800; i++) begin
                int r;
                bank_idle = (($urandom % 10) != 0);
                r = int'($urandom % 20);
                if (exp_cmd() == 4'b0001 && r < 14) drive(4'b0001);
                else if (r == 14)                   drive(4'b0001);
                else if (r == 15 || r == 16)        drive(4'b0010);
                else if (r == 17)                   drive(4'b0011);
                else                                drive(4'b1111);
                cyc();
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule